// File: doc/BRIEF.md
# Bus read-cycle handshake controller

This block runs one read transfer at a time between a bus master and a local device. It uses two four-phase handshakes that share one sequencer. The bus master raises a request strobe, and the controller forwards a strobe to the device. When the device acknowledges, the controller opens the data transceiver and then acknowledges the bus master. The return to zero runs in the reverse direction, with a fixed order of its own.

The controller is a clocked state machine. Both handshake inputs pass through a configurable synchroniser chain before they are used. All outputs come from registers, so they cannot glitch, and at most one of them changes on any clock edge. With all outputs low, the idle state and the state that waits for the device to release its acknowledge look the same, so a single internal bit tells them apart. A one-clock error pulse reports any handshake input that moves out of protocol order.

Top module: `bus_read_sequencer`

## Requirements
- R1: On a synchronous active-high reset, every output is 0. The controller then keeps all outputs at 0 for as long as the bus request stays low.
- R2: At most one of the three handshake outputs (`xcvr_en_o`, `bus_ack_o`, `local_strobe_o`) changes on any clock edge.
- R3: The rising phase follows a strict order. After the synchronised request is seen high, `local_strobe_o` rises first. `xcvr_en_o` rises after the synchronised device acknowledge is seen high. `bus_ack_o` rises on the following edge. Writing the output vector as {`xcvr_en_o`, `bus_ack_o`, `local_strobe_o`}, the values run 001, 101, 111.
- R4: After the synchronised request falls, `xcvr_en_o` falls first, then `bus_ack_o`, then `local_strobe_o`. The output vector runs 011, 001, 000.
- R5: `local_strobe_o` never rises for a new cycle while the device acknowledge from the previous cycle is still high. This holds even when the bus request has already risen again. The acknowledge must have been low for at least the synchroniser depth (two edges by default) before the strobe rises.
- R6: Both inputs pass through `SYNC_STAGES` flip-flops before they are used. The default is 2, and the value must be at least 2.
- R7: `proto_err_o` pulses for one clock when the device acknowledge rises while `local_strobe_o` is low.
- R8: `proto_err_o` pulses when the bus request falls after the strobe phase has started but before `bus_ack_o` has been asserted.
- R9: `proto_err_o` pulses when the bus request rises again while `bus_ack_o` is still high.
- R10: `proto_err_o` stays low through read cycles that follow the protocol, including a new request that arrives as soon as `bus_ack_o` has fallen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_req_i | input | 1 | Read request strobe from the bus master (asynchronous) |
| local_ack_i | input | 1 | Acknowledge from the local device (asynchronous) |
| bus_ack_o | output | 1 | Data acknowledge to the bus master |
| local_strobe_o | output | 1 | Strobe to the local device |
| xcvr_en_o | output | 1 | Enable for the data transceiver |
| proto_err_o | output | 1 | One-clock pulse when an input moves out of protocol order |

## Verification
A new bus request can arrive during the return-to-zero phase of the previous cycle. In that phase the controller has already lowered its strobe but is still waiting for the device acknowledge to fall. The bench provokes this overlap by raising the request again right after `bus_ack_o` falls, while the device model holds its acknowledge high for many more cycles. The overlap is judged in two ways. `local_strobe_o` must not rise until the acknowledge has been low for the synchroniser depth. The early but legal request must not produce any error pulse.

// File: rtl/bus_read_sequencer.sv
module bus_read_sequencer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_req_i,
  input  logic local_ack_i,
  output logic bus_ack_o,
  output logic local_strobe_o,
  output logic xcvr_en_o,
  output logic proto_err_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] req_sync, ack_sync;
  logic s_req, s_ack, req_prev, ack_prev;
  logic xcvr_q, back_q, strb_q, rtz_q;
  logic xcvr_n, back_n, strb_n, rtz_n;
  logic err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_sync <= '0;
      ack_sync <= '0;
      req_prev <= 1'b0;
      ack_prev <= 1'b0;
    end else begin
      req_sync <= {req_sync[LAST-1:0], strobe_req_i};
      ack_sync <= {ack_sync[LAST-1:0], local_ack_i};
      req_prev <= s_req;
      ack_prev <= s_ack;
    end
  end

  assign s_req = req_sync[LAST];
  assign s_ack = ack_sync[LAST];

  always_comb begin
    xcvr_n = xcvr_q;
    back_n = back_q;
    strb_n = strb_q;
    rtz_n  = rtz_q;
    case ({xcvr_q, back_q, strb_q, rtz_q})
      4'b0000: if (s_req && !s_ack) strb_n = 1'b1;
      4'b0010: if (s_ack) xcvr_n = 1'b1;
      4'b1010: back_n = 1'b1;
      4'b1110: if (!s_req) xcvr_n = 1'b0;
      4'b0110: begin back_n = 1'b0; rtz_n = 1'b1; end
      4'b0011: strb_n = 1'b0;
      4'b0001: if (!s_ack) rtz_n = 1'b0;
      default: begin
        xcvr_n = 1'b0;
        back_n = 1'b0;
        strb_n = 1'b0;
        rtz_n  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xcvr_q <= 1'b0;
      back_q <= 1'b0;
      strb_q <= 1'b0;
      rtz_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      xcvr_q <= xcvr_n;
      back_q <= back_n;
      strb_q <= strb_n;
      rtz_q  <= rtz_n;
      err_q  <= (s_ack & ~ack_prev & ~strb_q)
              | (~s_ack & ack_prev & strb_q)
              | (~s_req & req_prev & ~back_q & ~rtz_q)
              | (s_req & ~req_prev & back_q);
    end
  end

  assign xcvr_en_o      = xcvr_q;
  assign bus_ack_o      = back_q;
  assign local_strobe_o = strb_q;
  assign proto_err_o    = err_q;

  a_r2_single_change: assert property (@(posedge clk) disable iff (rst)
    $countones({xcvr_en_o, bus_ack_o, local_strobe_o} ^
               $past({xcvr_en_o, bus_ack_o, local_strobe_o})) <= 1);

  a_r3_xcvr_inside_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(xcvr_en_o) |-> local_strobe_o && !bus_ack_o);

  a_r3_ack_after_xcvr: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ack_o) |-> xcvr_en_o && $past(xcvr_en_o));

  a_r4_xcvr_falls_first: assert property (@(posedge clk) disable iff (rst)
    $fell(xcvr_en_o) |-> bus_ack_o && local_strobe_o);

  a_r4_strobe_falls_last: assert property (@(posedge clk) disable iff (rst)
    $fell(local_strobe_o) |-> !bus_ack_o && !xcvr_en_o);

  a_r5_no_early_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(local_strobe_o) |-> !$past(local_ack_i, 1) && !$past(local_ack_i, 2));

  initial a_r6_sync_depth: assert (SYNC_STAGES >= 2);

endmodule

// File: tb/bus_read_sequencer_test.sv
module bus_read_sequencer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic ack = 1'b0;
  logic bus_ack_o, local_strobe_o, xcvr_en_o, proto_err_o;

  bus_read_sequencer #(.SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .strobe_req_i(req), .local_ack_i(ack),
    .bus_ack_o(bus_ack_o), .local_strobe_o(local_strobe_o),
    .xcvr_en_o(xcvr_en_o), .proto_err_o(proto_err_o)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0, mon_on = 0, dev_on = 0, dev_slow = 0;
  int ack_low_cnt = 0, err_seen = 0;
  logic [2:0] prev_o = 3'b000, cur, e;
  logic [2:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cur = {xcvr_en_o, bus_ack_o, local_strobe_o};
    if (!rst) begin
      if (proto_err_o) err_seen++;
      if (mon_on && cur != prev_o) begin
        chk($countones(cur ^ prev_o) == 1, "R2 one output per edge", int'(cur), int'(prev_o));
        if (exp_q.size() == 0) chk(0, "R3 unexpected output event", int'(cur), 0);
        else begin
          e = exp_q.pop_front();
          chk(cur == e, "R3/R4 event order", int'(cur), int'(e));
        end
        if (cur[0] && !prev_o[0])
          chk(ack_low_cnt >= 3, "R5 strobe after ack low", ack_low_cnt, 3);
      end
    end
    prev_o = cur;
    ack_low_cnt = ack ? 0 : ack_low_cnt + 1;
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      if (dev_on) begin
        if (local_strobe_o && !ack) begin
          repeat ($urandom_range(0, 4)) @(posedge clk);
          #1 ack = 1'b1;
        end else if (!local_strobe_o && ack) begin
          repeat (dev_slow ? 15 : $urandom_range(0, 3)) @(posedge clk);
          #1 ack = 1'b0;
        end
      end
    end
  end

  task automatic do_reset;
    rst = 1'b1; req = 1'b0; ack = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic do_cycle(input int hold, input bit early);
    exp_q.push_back(3'b001);
    exp_q.push_back(3'b101);
    exp_q.push_back(3'b111);
    exp_q.push_back(3'b011);
    exp_q.push_back(3'b001);
    exp_q.push_back(3'b000);
    if (!req) begin @(posedge clk); #1 req = 1'b1; end
    wait (bus_ack_o);
    repeat (hold) @(posedge clk);
    #1 req = 1'b0;
    wait (!bus_ack_o);
    @(posedge clk);
    #1 if (early) req = 1'b1;
  endtask

  initial begin
    do_reset();
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(local_strobe_o == 0, "R1 strobe idle", local_strobe_o, 0);
    chk(bus_ack_o == 0, "R1 bus ack idle", bus_ack_o, 0);
    chk(xcvr_en_o == 0, "R1 xcvr idle", xcvr_en_o, 0);
    chk(proto_err_o == 0, "R1 error idle", proto_err_o, 0);

    err_seen = 0; mon_on = 1; dev_on = 1;
    for (int i = 0; i < 6; i++) do_cycle($urandom_range(0, 5), 1'b0);
    dev_slow = 1;
    for (int i = 0; i < 4; i++) do_cycle($urandom_range(0, 3), i < 3);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R3 all events seen", exp_q.size(), 0);
    chk(err_seen == 0, "R10 no error in legal cycles", err_seen, 0);
    mon_on = 0; dev_on = 0; dev_slow = 0;

    do_reset();
    err_seen = 0;
    ack = 1'b1; repeat (4) @(posedge clk);
    #1 ack = 1'b0; repeat (8) @(posedge clk);
    @(negedge clk);
    chk(err_seen == 1, "R7 ack without strobe", err_seen, 1);
    chk(local_strobe_o == 0, "R7 strobe stays low", local_strobe_o, 0);

    do_reset();
    err_seen = 0;
    req = 1'b1;
    wait (local_strobe_o);
    repeat (3) @(posedge clk);
    #1 req = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(err_seen == 1, "R8 request drop before bus ack", err_seen, 1);
    chk(bus_ack_o == 0, "R8 no bus ack", bus_ack_o, 0);

    do_reset();
    dev_on = 1; err_seen = 0;
    req = 1'b1;
    wait (bus_ack_o);
    @(posedge clk); #1 req = 1'b0;
    @(posedge clk); #1 req = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(err_seen == 1, "R9 request rise during bus ack", err_seen, 1);
    dev_on = 0;
    do_reset();

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule